// File: doc/BRIEF.md
# Ethernet Receive Descriptor Ring Writer

This block stores received Ethernet frames in memory through a ring of buffer descriptors. A frame is offered as a length followed by a byte stream. Before writing anything, the block walks the ring from its current descriptor. It accepts the frame only if enough descriptors are marked empty to hold it, assuming each one is filled up to the programmed maximum buffer size.

While the bytes arrive, the block spreads them over consecutive descriptor buffers. It then appends the four bytes of the CRC-32 frame check sequence after the payload. After each buffer it writes the descriptor status back. The descriptor that closes a frame carries a last marker plus any length or truncation error flags. Each buffer raises either a buffer event or a frame event.

When a frame is done, the block reads the next descriptor. Receive stays enabled only if that descriptor is empty. Otherwise new frames are drained and dropped until software re-arms the block. All memory traffic uses one 32-bit word-addressed master port with a single transaction outstanding.

Top module: `rx_ring_writer`

## Requirements
- R1: A descriptor is two big-endian words. The word at the descriptor address holds flags in bits 31:16 and length in bits 15:0. The next word holds the buffer address. In the flags, 0x8000 means empty, 0x2000 means wrap, 0x0800 means last, 0x0020 means length violation and 0x0001 means truncated. After a descriptor, the pointer moves to the ring base if wrap is set, and otherwise to the descriptor address plus 8. The ring base is taken with its two low bits cleared.
- R2: Before any memory write, the ring is walked from the current descriptor. Each empty descriptor covers up to one maximum buffer size of the stored length. If a non-empty descriptor is met before the stored length is covered, the frame is drained, ev_drop pulses and memory is not written.
- R3: Each buffer receives min(remaining stored bytes, maximum buffer size) bytes. Byte k of a buffer goes to buffer address + k, packed big-endian: offset 0 goes to bits 31:24. A stored length equal to the maximum buffer size uses exactly one descriptor.
- R4: The maximum buffer size is the written value ANDed with 0x7F0. A write whose masked value is zero selects 0x7F0. After reset the size is 0x7F0.
- R5: The stored length is the frame length plus 4. The 4 extra bytes follow the payload and hold the standard CRC-32 of the payload: reflected polynomial 0xEDB88320, all-ones preset, complemented result. Bits 31:24 of the CRC are stored first.
- R6: When the frame length plus 4 exceeds 2032, the stored length is 2032 and the last descriptor gets the truncated and length-violation flags. The bytes beyond 2032 are consumed from the stream and discarded.
- R7: If the stored length exceeds cfg_rx_limit, the last descriptor gets the length-violation flag. The frame is still stored. A stored length equal to the limit sets no flag.
- R8: Every filled descriptor has its empty flag cleared, its other flags (including wrap) kept, and its length field set to its byte count. Only the last descriptor gets the last flag and the error flags.
- R9: ev_buf pulses once for each filled descriptor that is not last. ev_frame pulses once for the last one.
- R10: After a frame, rx_enabled takes the empty flag of the next descriptor. While rx_enabled is low, offered frames are drained and ev_drop pulses. A pulse on rx_arm re-reads the current descriptor and sets rx_enabled from its empty flag.
- R11: At most one memory transaction is outstanding: no request is issued in the cycle after a read request. Every request address is word aligned.
- R12: After reset, rx_enabled is low, no request or event is active, and the ring pointer equals the aligned ring base. A pulse on ring_restart resets the pointer to that base and clears rx_enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ring_base | input | 32 | Ring base address (low two bits ignored) |
| cfg_rx_limit | input | 16 | Stored length above which the length-violation flag is set |
| cfg_bsz_we | input | 1 | Write strobe for the maximum buffer size |
| cfg_bsz_val | input | 11 | Value written to the maximum buffer size |
| ring_restart | input | 1 | Return the ring pointer to the base and disable receive |
| rx_arm | input | 1 | Re-read the current descriptor to enable receive |
| rx_enabled | output | 1 | Receive is enabled |
| frm_valid | input | 1 | A frame is offered |
| frm_len | input | 16 | Payload byte count of the offered frame |
| frm_ready | output | 1 | Frame offer is taken this cycle when frm_valid is high |
| byte_valid | input | 1 | Stream byte valid |
| byte_data | input | 8 | Stream byte |
| byte_ready | output | 1 | Stream byte is taken this cycle when byte_valid is high |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables, bit j enables bits 8j+7:8j |
| mem_rdata | input | 32 | Read data |
| mem_rvalid | input | 1 | Read data valid |
| ev_buf | output | 1 | A non-last buffer was completed |
| ev_frame | output | 1 | A frame was completed |
| ev_drop | output | 1 | A frame was dropped |

## Verification
The bench targets the edges of the room check. One frame needs one more descriptor than the ring offers. Another frame lands exactly on the maximum buffer size. A design with an off-by-one in the walk would either drop the second frame or overwrite the non-empty descriptor in the first.

Frames are split across three buffers, up to and including a wrapping descriptor. This exposes wrong byte lanes, CRC bytes written in the wrong order, a wrap that does not return to the base, and a stale receive-enable after the ring fills.

Oversize and over-limit frames check the error flags and the discard of the excess bytes. A block that failed to drain the tail would corrupt the frame that follows. Buffer-size writes of zero and of a value that masks to zero must both select the largest size.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_ARM_RD, S_ARM_W, S_CHK_RD, S_CHK_W, S_D0_RD, S_D0_W,
    S_D1_RD, S_D1_W, S_DATA, S_WR, S_WB, S_DRAIN, S_NX_RD, S_NX_W
  } rxw_state_e;

  localparam logic [15:0] FL_EMPTY = 16'h8000;
  localparam logic [15:0] FL_WRAP  = 16'h2000;
  localparam logic [15:0] FL_LAST  = 16'h0800;
  localparam logic [15:0] FL_LONG  = 16'h0020;
  localparam logic [15:0] FL_TRUNC = 16'h0001;
endpackage

// File: rtl/rxw_crc32.sv
module rxw_crc32 (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] fcs
);
  logic [31:0] crc_q;

  function automatic logic [31:0] step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int k = 0; k < 8; k++) begin
      if (r[0] ^ d[k]) r = (r >> 1) ^ 32'hEDB88320;
      else             r = r >> 1;
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clr) crc_q <= 32'hFFFF_FFFF;
    else if (en)    crc_q <= step(crc_q, din);
  end

  assign fcs = ~crc_q;
endmodule

// File: rtl/rxw_bufsize.sv
module rxw_bufsize #(
  parameter int BUF_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [BUF_W-1:0] wval,
  output logic [BUF_W-1:0] bsz
);
  localparam logic [BUF_W-1:0] BSZ_MAX = {{(BUF_W-4){1'b1}}, 4'b0000};

  logic [BUF_W-1:0] masked;
  assign masked = wval & BSZ_MAX;

  always_ff @(posedge clk) begin
    if (rst)     bsz <= BSZ_MAX;
    else if (we) bsz <= (masked == '0) ? BSZ_MAX : masked;
  end

  p_bsz_legal_r4: assert property (@(posedge clk) disable iff (rst)
    we |=> (bsz != '0) && (bsz[3:0] == 4'h0));
endmodule

// File: rtl/rxw_lane_pack.sv
module rxw_lane_pack (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        load,
  input  logic [1:0]  lane,
  input  logic [7:0]  din,
  output logic [31:0] word,
  output logic [3:0]  be
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      word <= '0;
      be   <= '0;
    end else if (load) begin
      word[{~lane, 3'b000} +: 8] <= din;
      be[~lane]                  <= 1'b1;
    end
  end

  p_lane_once_r3: assert property (@(posedge clk) disable iff (rst)
    (load && !clr) |=> be[~$past(lane)]);
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxw_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LW        = 16,
  parameter int BUF_W     = 11,
  parameter int MAX_FRAME = 2032
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    cfg_ring_base,
  input  logic [LW-1:0]    cfg_rx_limit,
  input  logic             cfg_bsz_we,
  input  logic [BUF_W-1:0] cfg_bsz_val,
  input  logic             ring_restart,
  input  logic             rx_arm,
  output logic             rx_enabled,
  input  logic             frm_valid,
  input  logic [LW-1:0]    frm_len,
  output logic             frm_ready,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  output logic             byte_ready,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  output logic [3:0]       mem_be,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_rvalid,
  output logic             ev_buf,
  output logic             ev_frame,
  output logic             ev_drop
);
  localparam int            FCS_BYTES  = 4;
  localparam logic [LW-1:0] MAXF       = LW'(MAX_FRAME);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(3);
  localparam logic [AW-1:0] DESC_STEP  = AW'(8);

  rxw_state_e    state_q;
  logic [AW-1:0] ptr_q, walk_q, waddr_q;
  logic [LW-1:0] len_q, stored_q, need_q, in_cnt_q, st_cnt_q, ch_len_q, ch_cnt_q;
  logic [15:0]   dflags_q, err_q;
  logic          drop_q, rx_en_q, arm_pend_q, rst_pend_q;

  logic [BUF_W-1:0] bsz_w;
  logic [LW-1:0]    maxbuf;
  logic [31:0]      fcs_w, pack_word;
  logic [3:0]       pack_be;

  rxw_bufsize #(.BUF_W(BUF_W)) u_bsz (
    .clk(clk), .rst(rst), .we(cfg_bsz_we), .wval(cfg_bsz_val), .bsz(bsz_w));
  assign maxbuf = LW'(bsz_w);

  // Frame admission arithmetic
  logic [LW:0]   len_plus;
  logic          trunc_c, long_c;
  logic [LW-1:0] stored_c;
  logic [15:0]   err_c;
  assign len_plus = {1'b0, frm_len} + (LW+1)'(FCS_BYTES);
  assign trunc_c  = len_plus > (LW+1)'(MAX_FRAME);
  assign stored_c = trunc_c ? MAXF : len_plus[LW-1:0];
  assign long_c   = trunc_c || (stored_c > cfg_rx_limit);
  assign err_c    = (trunc_c ? FL_TRUNC : 16'h0) | (long_c ? FL_LONG : 16'h0);

  logic [AW-1:0] base_al, ptr_adv;
  assign base_al = cfg_ring_base & ALIGN_MASK;
  assign ptr_adv = ((dflags_q & FL_WRAP) != 16'h0) ? base_al : ptr_q + DESC_STEP;

  logic [LW-1:0] rem_c, chunk_c, crc_off;
  assign rem_c   = stored_q - st_cnt_q;
  assign chunk_c = (rem_c <= maxbuf) ? rem_c : maxbuf;
  assign crc_off = st_cnt_q - len_q;

  // Byte source: stream payload first, then the check sequence
  logic       src_crc, take, last_c;
  logic [7:0] byte_mux;
  assign src_crc  = (in_cnt_q == len_q);
  assign byte_mux = src_crc ? fcs_w[{~crc_off[1:0], 3'b000} +: 8] : byte_data;
  assign take     = (state_q == S_DATA) && (src_crc || byte_valid);
  assign last_c   = (st_cnt_q == stored_q);

  rxw_crc32 u_crc (
    .clk(clk), .rst(rst), .clr(state_q == S_IDLE), .en(take && !src_crc),
    .din(byte_data), .fcs(fcs_w));

  rxw_lane_pack u_pack (
    .clk(clk), .rst(rst), .clr(state_q == S_WR), .load(take),
    .lane(ch_cnt_q[1:0]), .din(byte_mux), .word(pack_word), .be(pack_be));

  logic [15:0] wb_flags;
  assign wb_flags = (dflags_q & ~FL_EMPTY) | (last_c ? (FL_LAST | err_q) : 16'h0);

  assign frm_ready  = (state_q == S_IDLE) && !arm_pend_q && !rst_pend_q;
  assign byte_ready = ((state_q == S_DATA) && !src_crc) ||
                      ((state_q == S_DRAIN) && (in_cnt_q != len_q));
  assign rx_enabled = rx_en_q;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ptr_q;
    mem_wdata = 32'h0;
    mem_be    = 4'h0;
    unique case (state_q)
      S_ARM_RD, S_D0_RD, S_NX_RD: mem_req = 1'b1;
      S_CHK_RD: begin mem_req = 1'b1; mem_addr = walk_q; end
      S_D1_RD:  begin mem_req = 1'b1; mem_addr = ptr_q + AW'(4); end
      S_WR: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = waddr_q;
        mem_wdata = pack_word; mem_be = pack_be;
      end
      S_WB: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_wdata = {wb_flags, ch_len_q}; mem_be = 4'hF;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      ptr_q      <= cfg_ring_base & ALIGN_MASK;
      walk_q     <= '0;
      waddr_q    <= '0;
      len_q      <= '0;
      stored_q   <= '0;
      need_q     <= '0;
      in_cnt_q   <= '0;
      st_cnt_q   <= '0;
      ch_len_q   <= '0;
      ch_cnt_q   <= '0;
      dflags_q   <= '0;
      err_q      <= '0;
      drop_q     <= 1'b0;
      rx_en_q    <= 1'b0;
      arm_pend_q <= 1'b0;
      rst_pend_q <= 1'b0;
      ev_buf     <= 1'b0;
      ev_frame   <= 1'b0;
      ev_drop    <= 1'b0;
    end else begin
      ev_buf   <= 1'b0;
      ev_frame <= 1'b0;
      ev_drop  <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (rst_pend_q) begin
            ptr_q      <= base_al;
            rx_en_q    <= 1'b0;
            rst_pend_q <= 1'b0;
          end else if (arm_pend_q) begin
            if (rx_en_q) arm_pend_q <= 1'b0;
            else         state_q    <= S_ARM_RD;
          end else if (frm_valid) begin
            len_q    <= frm_len;
            stored_q <= stored_c;
            need_q   <= stored_c;
            err_q    <= err_c;
            in_cnt_q <= '0;
            st_cnt_q <= '0;
            walk_q   <= ptr_q;
            if (rx_en_q) begin
              drop_q  <= 1'b0;
              state_q <= S_CHK_RD;
            end else begin
              drop_q  <= 1'b1;
              ev_drop <= 1'b1;
              state_q <= S_DRAIN;
            end
          end
        end
        S_ARM_RD: state_q <= S_ARM_W;
        S_ARM_W: if (mem_rvalid) begin
          rx_en_q    <= mem_rdata[31];
          arm_pend_q <= 1'b0;
          state_q    <= S_IDLE;
        end
        S_CHK_RD: state_q <= S_CHK_W;
        S_CHK_W: if (mem_rvalid) begin
          if (!mem_rdata[31]) begin
            drop_q  <= 1'b1;
            ev_drop <= 1'b1;
            state_q <= S_DRAIN;
          end else if (need_q <= maxbuf) begin
            state_q <= S_D0_RD;
          end else begin
            need_q  <= need_q - maxbuf;
            walk_q  <= mem_rdata[29] ? base_al : walk_q + DESC_STEP;
            state_q <= S_CHK_RD;
          end
        end
        S_D0_RD: state_q <= S_D0_W;
        S_D0_W: if (mem_rvalid) begin
          dflags_q <= mem_rdata[31:16];
          state_q  <= S_D1_RD;
        end
        S_D1_RD: state_q <= S_D1_W;
        S_D1_W: if (mem_rvalid) begin
          waddr_q  <= mem_rdata & 32'hFFFF_FFFC;
          ch_len_q <= chunk_c;
          ch_cnt_q <= '0;
          state_q  <= S_DATA;
        end
        S_DATA: if (take) begin
          st_cnt_q <= st_cnt_q + 1'b1;
          ch_cnt_q <= ch_cnt_q + 1'b1;
          if (!src_crc) in_cnt_q <= in_cnt_q + 1'b1;
          if (ch_cnt_q[1:0] == 2'd3 || ch_cnt_q + 1'b1 == ch_len_q) state_q <= S_WR;
        end
        S_WR: begin
          waddr_q <= waddr_q + AW'(4);
          state_q <= (ch_cnt_q == ch_len_q) ? S_WB : S_DATA;
        end
        S_WB: begin
          ptr_q    <= ptr_adv;
          ev_frame <= last_c;
          ev_buf   <= !last_c;
          if (!last_c)                  state_q <= S_D0_RD;
          else if (in_cnt_q != len_q)   state_q <= S_DRAIN;
          else                          state_q <= S_NX_RD;
        end
        S_DRAIN: begin
          if (in_cnt_q == len_q)  state_q  <= drop_q ? S_IDLE : S_NX_RD;
          else if (byte_valid)    in_cnt_q <= in_cnt_q + 1'b1;
        end
        S_NX_RD: state_q <= S_NX_W;
        S_NX_W: if (mem_rvalid) begin
          rx_en_q <= mem_rdata[31];
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
      if (ring_restart) rst_pend_q <= 1'b1;
      if (rx_arm)       arm_pend_q <= 1'b1;
    end
  end

  // Assertions
  p_one_outstanding_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |=> !mem_req);
  p_word_aligned_r11: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00));
  p_chunk_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_WB) |-> (ch_len_q != '0) && (ch_len_q <= maxbuf));
  p_stored_cap_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_DATA) |-> (st_cnt_q < stored_q) && (stored_q <= MAXF));
  p_events_excl_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_buf, ev_frame, ev_drop}));
  p_drop_no_write_r2: assert property (@(posedge clk) disable iff (rst)
    ev_drop |=> !mem_req);
endmodule

// File: tb/rx_ring_writer_tb_top.sv
module rx_ring_writer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RING = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] cfg_ring_base = 32'h0000_0102;
  logic [15:0] cfg_rx_limit  = 16'hFFFF;
  logic        cfg_bsz_we = 1'b0;
  logic [10:0] cfg_bsz_val = '0;
  logic        ring_restart = 1'b0, rx_arm = 1'b0;
  logic        rx_enabled, frm_ready, byte_ready;
  logic        frm_valid = 1'b0, byte_valid = 1'b0;
  logic [15:0] frm_len = '0;
  logic [7:0]  byte_data = '0;
  logic        mem_req, mem_we, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [3:0]  mem_be;
  logic        ev_buf, ev_frame, ev_drop;

  rx_ring_writer dut_i (
    .clk(clk), .rst(rst), .cfg_ring_base(cfg_ring_base), .cfg_rx_limit(cfg_rx_limit),
    .cfg_bsz_we(cfg_bsz_we), .cfg_bsz_val(cfg_bsz_val), .ring_restart(ring_restart),
    .rx_arm(rx_arm), .rx_enabled(rx_enabled), .frm_valid(frm_valid), .frm_len(frm_len),
    .frm_ready(frm_ready), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_ready(byte_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
    .ev_buf(ev_buf), .ev_frame(ev_frame), .ev_drop(ev_drop));

  logic [31:0] mem [0:4095];
  int n_buf = 0, n_frame = 0, n_drop = 0, bad_mem = 0;
  int checks = 0, errors = 0;
  logic prev_read = 1'b0;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (!rst && mem_req) begin
      if (mem_addr[1:0] != 2'b00 || prev_read) bad_mem = bad_mem + 1;
      if (mem_we) begin
        for (int j = 0; j < 4; j++)
          if (mem_be[j]) mem[mem_addr[13:2]][8*j +: 8] = mem_wdata[8*j +: 8];
      end else begin
        mem_rdata  <= mem[mem_addr[13:2]];
        mem_rvalid <= 1'b1;
      end
    end
    prev_read <= mem_req && !mem_we;
    if (ev_buf)   n_buf   = n_buf + 1;
    if (ev_frame) n_frame = n_frame + 1;
    if (ev_drop)  n_drop  = n_drop + 1;
  end

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'(seed + i * 7 + (i >> 8));
  endfunction

  function automatic logic [31:0] fcs_ref(input int len, input int seed);
    logic [31:0] c;
    logic [7:0]  b;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < len; i++) begin
      b = pat(i, seed);
      for (int k = 0; k < 8; k++) c = (c[0] ^ b[k]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic logic [7:0] rd_byte(input logic [31:0] a);
    return mem[a[13:2]][8*(3 - int'(a[1:0])) +: 8];
  endfunction

  function automatic logic [31:0] desc_w0(input int d);
    return mem[(RING[13:2]) + 12'(2*d)];
  endfunction

  function automatic logic [31:0] buf_of(input int d);
    return 32'h1000 + 32'(d) * 32'h800;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Compare stored bytes against payload pattern positions [first, first+cnt)
  task automatic check_payload(input string req, input logic [31:0] base, input int first,
                               input int cnt, input int seed);
    int bad = -1;
    for (int i = 0; i < cnt; i++)
      if (bad < 0 && rd_byte(base + 32'(i)) !== pat(first + i, seed)) bad = i;
    if (bad < 0) check(req, 32'h0, 32'h0);
    else check(req, {24'h0, rd_byte(base + 32'(bad))}, {24'h0, pat(first + bad, seed)});
  endtask

  task automatic check_fcs(input string req, input logic [31:0] a, input int len, input int seed);
    logic [31:0] f;
    f = fcs_ref(len, seed);
    check(req, {rd_byte(a), rd_byte(a + 1), rd_byte(a + 2), rd_byte(a + 3)}, f);
  endtask

  task automatic pulse_bsz(input logic [10:0] v);
    @(negedge clk); cfg_bsz_we = 1'b1; cfg_bsz_val = v;
    @(negedge clk); cfg_bsz_we = 1'b0;
  endtask

  task automatic pulse_arm();
    @(negedge clk); rx_arm = 1'b1;
    @(negedge clk); rx_arm = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic ring_init(input logic [15:0] f0, input logic [15:0] f1,
                           input logic [15:0] f2, input logic [15:0] f3, input bit arm);
    logic [15:0] fl [4];
    fl[0] = f0; fl[1] = f1; fl[2] = f2; fl[3] = f3;
    @(negedge clk);
    for (int w = 12'h400; w < 12'hC00; w++) mem[w] = 32'hDEAD_BEEF;
    for (int d = 0; d < 4; d++) begin
      mem[RING[13:2] + 12'(2*d)]     = {fl[d], 16'h0};
      mem[RING[13:2] + 12'(2*d + 1)] = buf_of(d);
    end
    ring_restart = 1'b1;
    @(negedge clk); ring_restart = 1'b0;
    repeat (3) @(negedge clk);
    if (arm) pulse_arm();
  endtask

  task automatic send_frame(input int len, input int seed);
    int  i;
    bit  ok;
    n_buf = 0; n_frame = 0; n_drop = 0;
    @(negedge clk);
    frm_valid = 1'b1; frm_len = 16'(len);
    while (!frm_ready) @(negedge clk);
    @(negedge clk);
    frm_valid = 1'b0;
    i = 0;
    while (i < len) begin
      byte_data = pat(i, seed); byte_valid = 1'b1; ok = byte_ready;
      @(negedge clk);
      if (ok) i++;
    end
    byte_valid = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R12 rx_enabled after reset", {31'h0, rx_enabled}, 32'h0);
    check("R12 idle bus after reset", {28'h0, mem_req, ev_buf, ev_frame, ev_drop}, 32'h0);
  endtask

  task automatic t_disabled();
    ring_init(16'h8000, 16'h8000, 16'h8000, 16'hA000, 1'b0);
    send_frame(20, 3);
    check("R10 frame dropped while disabled", 32'(n_drop), 32'd1);
    check("R10 descriptor untouched", desc_w0(0), 32'h8000_0000);
    check("R10 buffer untouched", mem[12'h400], 32'hDEAD_BEEF);
    pulse_arm();
    check("R10 arm enables receive", {31'h0, rx_enabled}, 32'h1);
  endtask

  task automatic t_single();
    pulse_bsz(11'h000);
    send_frame(60, 11);
    check("R12 R8 R5 first descriptor at aligned base", desc_w0(0), {16'h0800, 16'd64});
    check_payload("R3 single buffer payload", buf_of(0), 0, 60, 11);
    check_fcs("R5 check sequence order", buf_of(0) + 60, 60, 11);
    check("R9 one frame event", 32'(n_frame), 32'd1);
    check("R9 no buffer event", 32'(n_buf), 32'd0);
    check("R10 stays enabled", {31'h0, rx_enabled}, 32'h1);
    send_frame(10, 5);
    check("R1 pointer steps by 8", desc_w0(1), {16'h0800, 16'd14});
  endtask

  task automatic t_multi();
    ring_init(16'h8000, 16'h8000, 16'h8000, 16'hA000, 1'b1);
    pulse_bsz(11'h000);
    send_frame(10, 2);
    pulse_bsz(11'h045);
    send_frame(150, 9);
    check("R4 R8 first of three buffers", desc_w0(1), {16'h0000, 16'd64});
    check("R8 middle buffer", desc_w0(2), {16'h0000, 16'd64});
    check("R8 last buffer keeps wrap", desc_w0(3), {16'h2800, 16'd26});
    check_payload("R3 split part 1", buf_of(1), 0, 64, 9);
    check_payload("R3 split part 2", buf_of(2), 64, 64, 9);
    check_payload("R3 split part 3", buf_of(3), 128, 22, 9);
    check_fcs("R5 check sequence in last buffer", buf_of(3) + 22, 150, 9);
    check("R9 buffer events", 32'(n_buf), 32'd2);
    check("R9 frame events", 32'(n_frame), 32'd1);
    check("R10 full ring disables", {31'h0, rx_enabled}, 32'h0);
    @(negedge clk); mem[RING[13:2]] = 32'h8000_0000;
    pulse_arm();
    check("R10 re-arm", {31'h0, rx_enabled}, 32'h1);
    send_frame(5, 1);
    check("R1 wrap returns to base", desc_w0(0), {16'h0800, 16'd9});
  endtask

  task automatic t_room();
    ring_init(16'h8000, 16'h8000, 16'h0000, 16'hA000, 1'b1);
    pulse_bsz(11'h040);
    send_frame(150, 4);
    check("R2 drop when ring short", 32'(n_drop), 32'd1);
    check("R2 nothing written", desc_w0(0), 32'h8000_0000);
    check("R2 buffer untouched", mem[12'h400], 32'hDEAD_BEEF);
    send_frame(100, 6);
    check("R2 fitting frame stored", desc_w0(0), {16'h0000, 16'd64});
    check("R2 fitting frame tail", desc_w0(1), {16'h0800, 16'd40});
    check_fcs("R5 fcs after split", buf_of(1) + 36, 100, 6);
    check("R10 next busy disables", {31'h0, rx_enabled}, 32'h0);
  endtask

  task automatic t_exact();
    ring_init(16'h8000, 16'h8000, 16'h8000, 16'hA000, 1'b1);
    pulse_bsz(11'h040);
    send_frame(60, 8);
    check("R3 exact fit one descriptor", desc_w0(0), {16'h0800, 16'd64});
    check("R3 no buffer event at exact fit", 32'(n_buf), 32'd0);
    pulse_bsz(11'h00F);
    send_frame(2000, 7);
    check("R4 masked zero selects largest", desc_w0(1), {16'h0800, 16'd2004});
  endtask

  task automatic t_limit();
    ring_init(16'h8000, 16'h8000, 16'h8000, 16'hA000, 1'b1);
    pulse_bsz(11'h000);
    cfg_rx_limit = 16'd50;
    send_frame(60, 12);
    check("R7 over limit flagged", desc_w0(0), {16'h0820, 16'd64});
    check_payload("R7 still stored", buf_of(0), 0, 60, 12);
    send_frame(46, 13);
    check("R7 equal to limit not flagged", desc_w0(1), {16'h0800, 16'd50});
    cfg_rx_limit = 16'hFFFF;
  endtask

  task automatic t_trunc();
    ring_init(16'h8000, 16'h8000, 16'h8000, 16'hA000, 1'b1);
    pulse_bsz(11'h000);
    send_frame(2100, 21);
    check("R6 truncated descriptor", desc_w0(0), {16'h0821, 16'd2032});
    check_payload("R6 truncated payload", buf_of(0), 0, 2032, 21);
    check("R6 one frame event", 32'(n_frame), 32'd1);
    send_frame(10, 22);
    check("R6 tail discarded, next frame clean", desc_w0(1), {16'h0800, 16'd14});
    check_payload("R6 next frame payload", buf_of(1), 0, 10, 22);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog act=expired exp=done");
    summary();
    $finish;
  end

  initial begin
    for (int w = 0; w < 4096; w++) mem[w] = 32'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_disabled();
    t_single();
    t_multi();
    t_room();
    t_exact();
    t_limit();
    t_trunc();
    check("R11 bus discipline", 32'(bad_mem), 32'd0);
    summary();
    $finish;
  end
endmodule